// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermarks

This block buffers data words between two unrelated clock domains. A producer on the write clock pushes words with a write enable. A consumer on the read clock pulls them back out with a read enable, in the same order they went in. Both clocks run all the time, and each enable decides whether its side acts on a given edge. Reads and writes may happen together. Storage is a two-port memory with `2**ADDR_W` entries. The write port is addressed by a write-side counter and the read port by a read-side counter. Each counter crosses to the other domain as a Gray code through a two-stage synchronizer.

Each side raises its own flags. The write side gives full, a programmable almost-full watermark and an overflow pulse. The read side gives empty, a programmable almost-empty watermark and an underflow pulse. Full and empty rise on the same edge as the operation that causes them. They fall only after the opposite pointer has crossed the synchronizer, so they may stay high for a few extra cycles.

A static mode input picks how the head word is presented:
- **Pull mode:** a word appears on the output only after an enabled read edge.
- **Fall-through mode:** the oldest word is loaded into an output register by itself, with a valid bit. Empty follows that valid bit, and each read consumes the word shown and fetches the next one. In this mode the buffer holds one extra word.

Change the mode only while both resets are high.

Top module: `dcfifo_flagged`

## Requirements
- R1: Words leave in exactly the order they were written, including while writes and reads run at the same time.
- R2: The write pointer moves only on a write-clock edge with `wr_en` high and `full` low, and the read pointer moves only when a word is popped. Each pointer step changes exactly one bit of its Gray code. With both enables low, the output data and all flags hold.
- R3: `full` is high at the first read-clock-independent sample after the write that leaves `2**ADDR_W` words in memory. After a read frees space, `full` falls within a few write-clock cycles.
- R4: `empty` is high on the edge of the read that takes the last word. After a write into an empty FIFO, `empty` falls within 2 to 6 read-clock cycles.
- R5: A write while `full` is ignored. The stored data and the read sequence are unchanged, and `overflow` is high for exactly the one following write-clock cycle.
- R6: A read while `empty` is ignored. `rd_data` holds its value, and `underflow` is high for exactly the one following read-clock cycle.
- R7: `almost_full` is high whenever the write-side count (write pointer minus synchronized read pointer) is greater than or equal to `af_thresh`.
- R8: `almost_empty` is high whenever the read-side count is less than or equal to `ae_thresh`. The read-side count is the synchronized write pointer minus the read pointer, plus one if the fall-through output register holds a word.
- R9: With `push_mode` = 0 (pull), `rd_data` changes only on a read edge with `empty` low. The word appears in the cycle after that edge, and nothing written reaches `rd_data` without a read.
- R10: With `push_mode` = 1 (fall-through), the oldest word is on `rd_data` with `empty` low and no read request. A read shows the next word on the following cycle, and the FIFO accepts `2**ADDR_W + 1` words before `full` stays high.
- R11: After reset, `empty` = 1, `full` = 0, `overflow` = 0, `underflow` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, free running |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request on this edge |
| wr_data | input | DATA_W | Word to store |
| af_thresh | input | ADDR_W+1 | Almost-full watermark |
| full | output | 1 | No space for another write |
| almost_full | output | 1 | Write-side count at or above watermark |
| overflow | output | 1 | One-cycle pulse after a rejected write |
| rd_clk | input | 1 | Read-side clock, free running |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request on this edge |
| push_mode | input | 1 | 0 = pull, 1 = fall-through; static outside reset |
| ae_thresh | input | ADDR_W+1 | Almost-empty watermark |
| rd_data | output | DATA_W | Head or last-read word |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Read-side count at or below watermark |
| underflow | output | 1 | One-cycle pulse after a rejected read |

## Verification
Some results arrive one cycle after their stimulus:
- **Immediate results:** `full` after a filling write, `empty` after a draining read, the overflow and underflow pulses, and a pulled word. The bench samples these on the falling edge right after the enabling rising edge.
- **Fall-through words:** these are checked both before the read and on the falling edge after it.
- **Cross-domain results:** flag release and watermark changes need two synchronizer stages plus one flag register in the receiving domain. The bench allows eight cycles of both clocks before sampling them.
- **Empty release:** this latency is measured directly by counting read-clock cycles, and the count must fall inside the two-to-six window.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        MODE_PULL = 1'b0,
        MODE_PUSH = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic full;
        logic afull;
        logic ovf;
    } wr_stat_t;

    typedef struct packed {
        logic empty;
        logic aempty;
        logic udf;
    } rd_stat_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [AW:0] rq2_gray,
    input  logic [AW:0] af_thresh,
    output logic [AW-1:0] waddr,
    output logic        we,
    output logic [AW:0] wgray,
    output wr_stat_t    stat
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, bin_nxt, gray_nxt, level;
    logic          full_q, ovf_q;

    assign we       = wr_en & ~full_q;
    assign bin_nxt  = wbin + PW'(we);
    assign gray_nxt = PW'(bin2gray(32'(bin_nxt)));
    assign level    = wbin - PW'(gray2bin(32'(rq2_gray)));
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            wbin   <= bin_nxt;
            wgray  <= gray_nxt;
            full_q <= (gray_nxt == {~rq2_gray[PW-1:PW-2], rq2_gray[PW-3:0]});
            ovf_q  <= wr_en & full_q;
        end
    end

    assign stat.full  = full_q;
    assign stat.afull = (level >= af_thresh);
    assign stat.ovf   = ovf_q;

    // R2: one Gray bit per step
    p_gray_step_wr_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    // R5: rejected write leaves the pointer alone
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full_q) |=> $stable(wbin));
    // R5: rejected write raises the pulse
    p_ovf_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full_q) |=> ovf_q);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  rd_mode_e    mode,
    input  logic [AW:0] wq2_gray,
    input  logic [AW:0] ae_thresh,
    output logic [AW-1:0] raddr,
    output logic        pop,
    output logic [AW:0] rgray,
    output rd_stat_t    stat
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, bin_nxt, gray_nxt, level;
    logic          mem_empty, valid, udf_q, empty_o;

    generate
        assign pop = ~mem_empty & ((mode == MODE_PUSH) ? (~valid | rd_en) : rd_en);
    endgenerate

    assign bin_nxt  = rbin + PW'(pop);
    assign gray_nxt = PW'(bin2gray(32'(bin_nxt)));
    assign raddr    = rbin[AW-1:0];
    assign empty_o  = (mode == MODE_PUSH) ? ~valid : mem_empty;
    assign level    = PW'(gray2bin(32'(wq2_gray))) - rbin + PW'(valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin      <= '0;
            rgray     <= '0;
            mem_empty <= 1'b1;
            valid     <= 1'b0;
            udf_q     <= 1'b0;
        end else begin
            rbin      <= bin_nxt;
            rgray     <= gray_nxt;
            mem_empty <= (gray_nxt == wq2_gray);
            valid     <= (mode == MODE_PUSH) ? (pop | (valid & ~rd_en)) : 1'b0;
            udf_q     <= rd_en & empty_o;
        end
    end

    assign stat.empty  = empty_o;
    assign stat.aempty = (level <= ae_thresh);
    assign stat.udf    = udf_q;

    // R2: one Gray bit per step
    p_gray_step_rd_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
    // R6: rejected read in pull mode leaves the pointer alone
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PULL && rd_en && empty_o) |=> $stable(rbin));
    // R6: rejected read raises the pulse
    p_udf_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty_o) |=> udf_q);
endmodule

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged
    import dcfifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4   // at least 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   af_thresh,
    output logic              full,
    output logic              almost_full,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic              push_mode,
    input  logic [ADDR_W:0]   ae_thresh,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              underflow
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wq2, rq2;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we, pop;
    wr_stat_t          wst;
    rd_stat_t          rst_s;
    rd_mode_e          mode;

    assign mode = rd_mode_e'(push_mode);

    fifo_wr_side #(.AW(ADDR_W)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rq2_gray(rq2),
        .af_thresh(af_thresh), .waddr(waddr), .we(we), .wgray(wgray), .stat(wst)
    );

    fifo_rd_side #(.AW(ADDR_W)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .mode(mode), .wq2_gray(wq2),
        .ae_thresh(ae_thresh), .raddr(raddr), .pop(pop), .rgray(rgray), .stat(rst_s)
    );

    fifo_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wq2));
    fifo_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rq2));

    fifo_dpram #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(pop), .raddr(raddr), .rdata(rd_data)
    );

    assign full         = wst.full;
    assign almost_full  = wst.afull;
    assign overflow     = wst.ovf;
    assign empty        = rst_s.empty;
    assign almost_empty = rst_s.aempty;
    assign underflow    = rst_s.udf;

    // R9: pull-mode output moves only on a read
    p_pull_hold_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!push_mode && !rd_en) |=> $stable(rd_data));
    // R10: fall-through head word stays put until consumed
    p_push_hold_r10: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (push_mode && !empty && !rd_en) |=> (!empty && $stable(rd_data)));
endmodule

// File: tb/dcfifo_flagged_bench.sv
`timescale 1ns/100ps
module dcfifo_flagged_bench;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1, wr_en = 0, rd_en = 0, push_mode = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0] af_thresh = '0, ae_thresh = '0;
    logic full, almost_full, overflow, empty, almost_empty, underflow;
    logic [DW-1:0] rd_data;

    int nchk = 0, nfail = 0;

    always #4 wr_clk = ~wr_clk;
    initial begin
        #1.5;
        forever #4 rd_clk = ~rd_clk;
    end

    dcfifo_flagged #(.DATA_W(DW), .ADDR_W(AW)) u_dcfifo_flagged (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .af_thresh(af_thresh), .full(full), .almost_full(almost_full),
        .overflow(overflow), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .push_mode(push_mode), .ae_thresh(ae_thresh), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty), .underflow(underflow)
    );

    typedef struct packed {
        logic       mode;
        logic [5:0] nwr;
        logic [4:0] af;
        logic [4:0] ae;
        logic       exp_full;
        logic       exp_af;
        logic       exp_ae;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 6'd0,  5'd12, 5'd2, 1'b0, 1'b0, 1'b1},
        '{1'b0, 6'd5,  5'd5,  5'd4, 1'b0, 1'b1, 1'b0},
        '{1'b0, 6'd16, 5'd15, 5'd3, 1'b1, 1'b1, 1'b0},
        '{1'b1, 6'd5,  5'd5,  5'd5, 1'b0, 1'b0, 1'b1},
        '{1'b1, 6'd17, 5'd16, 5'd1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 6'd3,  5'd2,  5'd3, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic m, logic [AW:0] af, logic [AW:0] ae);
        wr_rst = 1; rd_rst = 1; wr_en = 0; rd_en = 0;
        push_mode = m; af_thresh = af; ae_thresh = ae;
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk) wr_rst = 0;
        @(negedge rd_clk) rd_rst = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge wr_clk);
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic write_word(logic [DW-1:0] d);
        @(negedge wr_clk);
        for (int n = 0; n < 100 && full; n++) @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic read_word(output logic [DW-1:0] d);
        @(negedge rd_clk);
        for (int n = 0; n < 100 && empty; n++) @(negedge rd_clk);
        if (push_mode) begin
            d = rd_data;
            rd_en = 1;
            @(negedge rd_clk);
            rd_en = 0;
        end else begin
            rd_en = 1;
            @(negedge rd_clk);
            rd_en = 0;
            d = rd_data;
        end
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] keep;
        int lat;

        // table-driven pass: fill, check watermarks, drain
        for (int k = 0; k < 6; k++) begin
            do_reset(VECS[k].mode, VECS[k].af, VECS[k].ae);
            for (int i = 0; i < int'(VECS[k].nwr); i++) write_word(DW'(16*k + i + 1));
            settle();
            chk("R3", "full after fill", int'(full), int'(VECS[k].exp_full));
            chk("R7", "almost_full", int'(almost_full), int'(VECS[k].exp_af));
            chk("R8", "almost_empty", int'(almost_empty), int'(VECS[k].exp_ae));
            chk("R4", "empty after fill", int'(empty), int'(VECS[k].nwr == 0));
            if (VECS[k].nwr != 0) begin
                if (VECS[k].mode)
                    chk("R10", "head word shown without read", int'(rd_data), 16*k + 1);
                else
                    chk("R9", "no data before read", int'(rd_data), 0);
            end
            for (int i = 0; i < int'(VECS[k].nwr); i++) begin
                read_word(d);
                chk("R1", "read order", int'(d), (16*k + i + 1) % 256);
            end
            chk("R4", "empty right after last read", int'(empty), 1);
        end

        // R11: reset state
        do_reset(1'b0, 5'd4, 5'd2);
        @(negedge wr_clk);
        chk("R11", "full at reset", int'(full), 0);
        chk("R11", "overflow at reset", int'(overflow), 0);
        @(negedge rd_clk);
        chk("R11", "empty at reset", int'(empty), 1);
        chk("R11", "underflow at reset", int'(underflow), 0);
        chk("R11", "rd_data at reset", int'(rd_data), 0);

        // R6: read while empty
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        chk("R6", "underflow pulse", int'(underflow), 1);
        chk("R6", "rd_data unchanged", int'(rd_data), 0);
        @(negedge rd_clk);
        chk("R6", "underflow one cycle", int'(underflow), 0);

        // R3/R5: fill, overflow attempt, drain
        for (int i = 0; i < DEPTH; i++) begin
            write_word(DW'(8'h40 + i));
            if (i == DEPTH - 1) chk("R3", "full on filling write", int'(full), 1);
            else if (i == DEPTH - 2) chk("R3", "not full one short", int'(full), 0);
        end
        wr_en = 1; wr_data = 8'hEE;
        @(negedge wr_clk);
        wr_en = 0;
        chk("R5", "overflow pulse", int'(overflow), 1);
        @(negedge wr_clk);
        chk("R5", "overflow one cycle", int'(overflow), 0);
        for (int i = 0; i < DEPTH; i++) begin
            read_word(d);
            chk("R5", "data intact after rejected write", int'(d), 8'h40 + i);
        end
        chk("R5", "nothing extra stored", int'(empty), 1);
        settle();
        chk("R3", "full released", int'(full), 0);

        // R2: idle cycles change nothing
        do_reset(1'b0, 5'd8, 5'd1);
        for (int i = 0; i < 3; i++) write_word(DW'(8'h70 + i));
        settle();
        read_word(d);
        keep = rd_data;
        repeat (10) @(negedge rd_clk);
        chk("R2", "rd_data holds while idle", int'(rd_data), int'(keep));
        chk("R2", "empty holds while idle", int'(empty), 0);
        chk("R2", "almost_empty holds", int'(almost_empty), 0);
        read_word(d);
        chk("R2", "next word after idle", int'(d), 8'h71);
        read_word(d);
        chk("R2", "last word after idle", int'(d), 8'h72);

        // R4: empty release latency
        do_reset(1'b0, 5'd8, 5'd1);
        @(negedge wr_clk);
        wr_en = 1; wr_data = 8'h5A;
        @(posedge wr_clk);
        #0.1 wr_en = 0;
        lat = 0;
        while (empty && lat < 20) begin
            @(negedge rd_clk);
            lat++;
        end
        nchk++;
        if (lat < 2 || lat > 6) begin
            nfail++;
            $display("FAIL R4 empty release: got %0d expected 2..6", lat);
        end
        read_word(d);
        chk("R9", "word after read", int'(d), 8'h5A);

        // R1: concurrent streaming, both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0], 5'd8, 5'd1);
            fork
                for (int i = 0; i < 40; i++) write_word(DW'(8'h90 + i + m));
                begin
                    logic [DW-1:0] q;
                    for (int i = 0; i < 40; i++) begin
                        read_word(q);
                        chk("R1", "concurrent order", int'(q), (8'h90 + i + m) % 256);
                    end
                end
            join
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule